// File: doc/BRIEF.md
# Multilevel Reference Level Decomposer

This block prepares a three-phase reference for a zero common-mode multilevel modulator. Each phase arrives as an unsigned fixed-point voltage on the scale 0 to n-1, where n is the odd number of inverter levels. The block splits each phase into an integer base level and a fractional active duty. It adds the three base levels and derives the total active voltage, which is the amount the three switching phases must contribute so that the average common-mode voltage is zero. That total picks one of two switching patterns for the downstream pulse generator.

A triple of references enters through a valid/ready handshake. The results leave through a second valid/ready handshake, one register stage later. The output stage holds one result. Input ready is high when that stage is empty or when its result is taken in the same cycle. While `out_valid` is high and `out_ready` is low, the held result does not change and no new triple is accepted. A sum of base levels that does not lead to a total active value of 1 or 2 raises an error flag and leaves the pattern unchanged. The parameter `N_LEVELS` must be odd and at least 3; any other value stops elaboration.

Top module: `mlvl_ref_decomp`

## Requirements
- R1: Each phase's output base level is the integer part of its reference. It never exceeds n-2.
- R2: A reference equal to n-1, or larger, gives base level n-2 and duty 1.0, which is the code 65536.
- R3: Each phase's duty equals its reference minus its base level times 65536. It lies in 0 to 65536, with 16 fractional bits.
- R4: The total active value is 3(n-1)/2 minus the sum of the three base levels. A value of 2 sets `pattern_o` to 0. This is the pattern whose active states have two phases high: 110, 011 and 101.
- R5: A total active value of 1 sets `pattern_o` to 1. This is the pattern whose active states have one phase high: 100, 010 and 001.
- R6: Any other total active value sets `err_o` to 1 for that result and keeps `pattern_o` at its previous value. A valid value sets `err_o` to 0.
- R7: A triple accepted at a clock edge shows its results, with `out_valid` high, right after that edge.
- R8: `in_ready` equals `!out_valid || out_ready`. While a result is stalled, all outputs stay stable.
- R9: After reset, `out_valid`, `pattern_o`, `err_o`, the base levels and the duties are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A reference triple is presented |
| in_ready | output | 1 | The block can take a triple this cycle |
| ref_abc | input | 3*REF_W | References, phase A in the low slice; REF_W = clog2(N_LEVELS)+16 |
| out_valid | output | 1 | The output result is valid |
| out_ready | input | 1 | The consumer takes the result this cycle |
| base_abc | output | 3*LVL_W | Base levels, phase A in the low slice; LVL_W = clog2(N_LEVELS) |
| duty_abc | output | 3*17 | Active duties, phase A in the low slice |
| pattern_o | output | 1 | 0 selects the two-high pattern, 1 selects the one-high pattern |
| err_o | output | 1 | The total active value was neither 1 nor 2 |

## Verification
All results of an accepted triple are due at the clock edge that accepts it: base levels, duties, pattern, error flag and `out_valid`. `in_ready` is combinational in the same cycle. The bench keeps a behavioural model. The model advances on exactly the handshakes the bench drives. The bench compares every output against the model at each falling edge, half a cycle after the registers move. It compares `in_ready` one time step after changing `out_ready`. Random valid and ready patterns create stalls, so the bench also checks that the held values stay unchanged.

// File: rtl/mlvl_decomp_pkg.sv
package mlvl_decomp_pkg;

  // Switching pattern chosen from the total active value
  typedef enum logic {
    PAT_TWO_HIGH = 1'b0,   // total active value 2
    PAT_ONE_HIGH = 1'b1    // total active value 1
  } pattern_e;

  localparam int FRAC_BITS = 16;

endpackage

// File: rtl/mlvl_phase_split.sv
module mlvl_phase_split #(
  parameter int N_LEVELS = 5,
  parameter int FRAC_W   = 16,
  localparam int LVL_W   = $clog2(N_LEVELS),
  localparam int REF_W   = LVL_W + FRAC_W,
  localparam int DUTY_W  = FRAC_W + 1
) (
  input  logic [REF_W-1:0]  ref_i,
  output logic [LVL_W-1:0]  base_o,
  output logic [DUTY_W-1:0] duty_o
);

  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(N_LEVELS - 1);
  localparam logic [LVL_W-1:0] LVL_CAP  = LVL_W'(N_LEVELS - 2);
  localparam logic [REF_W-1:0] REF_TOP  = {LVL_TOP, {FRAC_W{1'b0}}};

  logic [REF_W-1:0] clipped;
  logic [LVL_W-1:0] int_part;
  logic [REF_W-1:0] diff;

  always_comb begin
    // saturate out-of-range references to the top level
    clipped  = (ref_i > REF_TOP) ? REF_TOP : ref_i;
    int_part = clipped[REF_W-1:FRAC_W];
    // the top level keeps the active part inside 0..1
    base_o   = (int_part >= LVL_TOP) ? LVL_CAP : int_part;
    diff     = clipped - {base_o, {FRAC_W{1'b0}}};
    duty_o   = diff[DUTY_W-1:0];
  end

endmodule

// File: rtl/mlvl_pattern_pick.sv
module mlvl_pattern_pick
  import mlvl_decomp_pkg::*;
#(
  parameter int N_LEVELS = 5,
  localparam int LVL_W   = $clog2(N_LEVELS),
  localparam int SUM_W   = LVL_W + 2,
  localparam int FE_W    = SUM_W + 2
) (
  input  logic [3*LVL_W-1:0] base_abc,
  output logic               sel_ok,
  output pattern_e           sel_pat
);

  localparam int FE_TOTAL = 3 * (N_LEVELS - 1) / 2;

  logic [SUM_W-1:0]       base_sum;
  logic signed [FE_W-1:0] fe;

  always_comb begin
    base_sum = '0;
    for (int k = 0; k < 3; k++)
      base_sum = base_sum + SUM_W'(base_abc[k*LVL_W +: LVL_W]);
    fe      = FE_W'(FE_TOTAL) - FE_W'(base_sum);
    sel_ok  = (fe == FE_W'(1)) || (fe == FE_W'(2));
    sel_pat = (fe == FE_W'(1)) ? PAT_ONE_HIGH : PAT_TWO_HIGH;
  end

endmodule

// File: rtl/mlvl_ref_decomp.sv
module mlvl_ref_decomp
  import mlvl_decomp_pkg::*;
#(
  parameter int N_LEVELS = 5,
  parameter int FRAC_W   = FRAC_BITS,
  localparam int LVL_W   = $clog2(N_LEVELS),
  localparam int REF_W   = LVL_W + FRAC_W,
  localparam int DUTY_W  = FRAC_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [3*REF_W-1:0]  ref_abc,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [3*LVL_W-1:0]  base_abc,
  output logic [3*DUTY_W-1:0] duty_abc,
  output logic                pattern_o,
  output logic                err_o
);

  generate
    if ((N_LEVELS % 2) == 0 || N_LEVELS < 3) begin : g_bad_levels
      $error("N_LEVELS must be odd and at least 3");
    end
  endgenerate

  localparam logic [DUTY_W-1:0] DUTY_ONE = DUTY_W'(1) << FRAC_W;

  logic [3*LVL_W-1:0]  base_c;
  logic [3*DUTY_W-1:0] duty_c;
  logic                sel_ok;
  pattern_e            sel_pat;
  logic                in_fire;

  for (genvar p = 0; p < 3; p++) begin : g_phase
    mlvl_phase_split #(.N_LEVELS(N_LEVELS), .FRAC_W(FRAC_W)) u_split (
      .ref_i  (ref_abc[p*REF_W +: REF_W]),
      .base_o (base_c[p*LVL_W +: LVL_W]),
      .duty_o (duty_c[p*DUTY_W +: DUTY_W])
    );
  end

  mlvl_pattern_pick #(.N_LEVELS(N_LEVELS)) u_pick (
    .base_abc (base_c),
    .sel_ok   (sel_ok),
    .sel_pat  (sel_pat)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      base_abc  <= '0;
      duty_abc  <= '0;
      pattern_o <= PAT_TWO_HIGH;
      err_o     <= 1'b0;
    end else begin
      if (in_fire) begin
        out_valid <= 1'b1;
        base_abc  <= base_c;
        duty_abc  <= duty_c;
        err_o     <= !sel_ok;
        if (sel_ok) pattern_o <= sel_pat;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_chk
    // R1
    base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_abc[p*LVL_W +: LVL_W] <= LVL_W'(N_LEVELS - 2));
    // R3
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      duty_abc[p*DUTY_W +: DUTY_W] <= DUTY_ONE);
  end

  // R6
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !sel_ok) |=> ($stable(pattern_o) && err_o));

  // R7
  fire_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(base_abc)
      && $stable(duty_abc) && $stable(pattern_o) && $stable(err_o)));

endmodule

// File: tb/mlvl_ref_decomp_test.sv
module mlvl_ref_decomp_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL     = 5;
  localparam int FW     = 16;
  localparam int LW     = $clog2(NL);
  localparam int RW     = LW + FW;
  localparam int DW     = FW + 1;
  localparam int ONE    = 1 << FW;
  localparam int TOPREF = (NL - 1) << FW;
  localparam int NCYC   = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [3*RW-1:0] ref_abc = '0;
  logic in_ready, out_valid, pattern_o, err_o;
  logic [3*LW-1:0] base_abc;
  logic [3*DW-1:0] duty_abc;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural model state
  int  e_base[3];
  int  e_duty[3];
  bit  e_sat[3];
  int  e_fe = 0;
  bit  e_v = 0, e_pat = 0, e_err = 0;

  mlvl_ref_decomp #(.N_LEVELS(NL)) uut (
    .clk, .rst_n, .in_valid, .in_ready, .ref_abc, .out_valid, .out_ready,
    .base_abc, .duty_abc, .pattern_o, .err_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_outputs();
    chk("R7 out_valid", int'(out_valid), int'(e_v));
    for (int p = 0; p < 3; p++) begin
      chk("R1 base", int'(base_abc[p*LW +: LW]), e_base[p]);
      if (e_sat[p]) chk("R2 top duty", int'(duty_abc[p*DW +: DW]), e_duty[p]);
      else          chk("R3 duty", int'(duty_abc[p*DW +: DW]), e_duty[p]);
    end
    if (e_err)        chk("R6 pattern held", int'(pattern_o), int'(e_pat));
    else if (e_fe == 1) chk("R5 pattern", int'(pattern_o), int'(e_pat));
    else              chk("R4 pattern", int'(pattern_o), int'(e_pat));
    chk("R6 err", int'(err_o), int'(e_err));
  endtask

  task automatic model_accept(input int r0, input int r1, input int r2);
    int rr[3];
    int sum;
    rr[0] = r0; rr[1] = r1; rr[2] = r2;
    sum = 0;
    for (int p = 0; p < 3; p++) begin
      int rc;
      rc = (rr[p] > TOPREF) ? TOPREF : rr[p];
      e_sat[p]  = (rc == TOPREF);
      e_base[p] = rc / ONE;
      if (e_base[p] > NL - 2) e_base[p] = NL - 2;
      e_duty[p] = rc - e_base[p] * ONE;
      sum += e_base[p];
    end
    e_fe  = 3 * (NL - 1) / 2 - sum;
    e_err = !(e_fe == 1 || e_fe == 2);
    if (!e_err) e_pat = (e_fe == 1);
    e_v = 1;
  endtask

  int dir[8][3] = '{
    '{0, 0, 0},                                  // fe 6 -> error
    '{3*ONE + 100, 1*ONE + 5000, 0*ONE + 200},   // sum 4 -> fe 2
    '{3*ONE + 300, 2*ONE + 7, ONE/2},            // sum 5 -> fe 1
    '{TOPREF, 1*ONE + 10, 0},                    // top value, sum 4
    '{TOPREF, TOPREF, TOPREF},                   // sum 9 -> error
    '{TOPREF + 9000, 2*ONE, 0},                  // over range, sum 5
    '{2*ONE, 2*ONE, 2*ONE - 1},                  // sum 5 -> fe 1
    '{2*ONE, 2*ONE, 0}                           // sum 4 -> fe 2
  };

  initial begin
    for (int p = 0; p < 3; p++) begin
      e_base[p] = 0; e_duty[p] = 0; e_sat[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 pattern", int'(pattern_o), 0);
    chk("R9 err", int'(err_o), 0);
    chk("R9 base", int'(base_abc), 0);
    chk("R9 duty", int'(duty_abc), 0);
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int r[3];
      bit v, rd;
      cmp_outputs();
      if (cyc < 8) begin
        v = 1; rd = 1;
        for (int p = 0; p < 3; p++) r[p] = dir[cyc][p];
      end else begin
        v  = ($urandom_range(0, 3) != 0);
        rd = ($urandom_range(0, 3) != 0);
        for (int p = 0; p < 3; p++) begin
          case ($urandom_range(0, 5))
            0:       r[p] = TOPREF;
            1:       r[p] = TOPREF + $urandom_range(1, 60000);
            2:       r[p] = $urandom_range(0, NL - 1) * ONE;
            default: r[p] = $urandom_range(0, TOPREF);
          endcase
        end
      end
      in_valid  = v;
      out_ready = rd;
      ref_abc   = {RW'(r[2]), RW'(r[1]), RW'(r[0])};
      #1;
      chk("R8 in_ready", int'(in_ready), int'(!e_v || rd));
      if (v && (!e_v || rd)) model_accept(r[0], r[1], r[2]);
      else if (rd) e_v = 0;
      @(negedge clk);
    end
    cmp_outputs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule